// File: doc/BRIEF.md
# Cluster Invalidation Fan-out Combiner

This block is the coherence controller slice of a cluster-level shared cache. For each block it keeps a valid bit, a write-permission bit and a sharer vector with one bit per private cache in the cluster. Cores in other clusters never appear in the vector. Core requests (read or write) are served locally when the cluster already holds the needed permission. A request that lacks the needed permission is forwarded to the last-level cache, and the block waits for the upstream grant.

An invalidation from the last-level cache names the cluster as a whole. The block sends one invalidation pulse to the private caches whose sharer bits are set, and to no other cache. It counts their acknowledgments with a counter loaded from the popcount of the vector. It then returns a single acknowledgment upstream, so upstream traffic does not depend on how many local cores held the block. When the combined acknowledgment has been handed over, the block is invalid in the cluster and its sharer vector is empty.

A local write that already has cluster write permission uses the same fan-out engine to invalidate the other local sharers before the grant. The slice handles one transaction at a time, so a second request for a block is held until the first one completes.

Top module: `cic_combiner`

## Requirements
- R1: In the cycle after an upstream invalidation is accepted, `linv_mask` equals the block's sharer vector (bit i = core i) for exactly one cycle, and it is zero in the following cycle.
- R2: Exactly one `uack_valid` is raised per accepted invalidation. It rises in the cycle after the last pending local acknowledgment is sampled, carries the invalidated block on `uack_blk`, and drops after the `uack_valid && uack_ready` handshake.
- R3: If the sharer vector is empty when an invalidation is accepted, `uack_valid` is high in the next cycle and no local invalidation is sent.
- R4: A local acknowledgment from a core with no invalidation pending (a non-sharer, or a core that has already acknowledged) does not advance completion.
- R5: After the combined acknowledgment, the block is invalid with no sharers, so a later read of it is forwarded upstream (`ureq_write` = 0).
- R6: A core write to a block without cluster write permission is forwarded upstream with `ureq_write` = 1 and the block index on `ureq_blk`. No grant is given to the core before `ugnt_valid`.
- R7: When the upstream grant for a forwarded write arrives, any other local sharers get one invalidation pulse. After their acks (or at once if there are none), the core gets `cgnt_valid` with `cgnt_write` = 1 and becomes the only sharer, with write permission.
- R8: A read of a valid block is granted in the cycle after acceptance with no upstream request, and the reading core is added to the sharer vector. `cgnt_valid` lasts one cycle.
- R9: A write to a block that already has write permission invalidates the other local sharers and is granted after their last ack. With no other sharers it is granted in the cycle after acceptance.
- R10: Only one transaction is in flight: `uinv_ready` and `creq_ready` are low while it runs. When an upstream invalidation and a core request are both valid in an idle cycle, the invalidation is taken.
- R11: After reset every block is invalid with an empty sharer vector, both readies are high, and all outgoing valids and `linv_mask` are zero.
- R12: `uack_valid` with `uack_blk`, and `ureq_valid` with `ureq_blk`/`ureq_write`, stay stable until their ready is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| creq_valid | input | 1 | Core request valid |
| creq_ready | output | 1 | Core request accepted |
| creq_core | input | CIW | Requesting core index |
| creq_blk | input | BW | Requested block index |
| creq_write | input | 1 | 1 = write request, 0 = read request |
| cgnt_valid | output | 1 | One-cycle grant to a core |
| cgnt_core | output | CIW | Granted core |
| cgnt_blk | output | BW | Granted block |
| cgnt_write | output | 1 | Grant carries write permission |
| linv_mask | output | N | One-cycle invalidation pulse, one bit per local cache |
| linv_blk | output | BW | Block being invalidated locally |
| lack | input | N | Local invalidation acknowledgments, one bit per core |
| ureq_valid | output | 1 | Request forwarded to the last-level cache |
| ureq_ready | input | 1 | Upstream accepts the request |
| ureq_blk | output | BW | Forwarded block |
| ureq_write | output | 1 | Forwarded request asks for write permission |
| ugnt_valid | input | 1 | Upstream grant for the outstanding request |
| uinv_valid | input | 1 | Invalidation from the last-level cache |
| uinv_ready | output | 1 | Invalidation accepted |
| uinv_blk | input | BW | Block to invalidate |
| uack_valid | output | 1 | Combined acknowledgment to the last-level cache |
| uack_ready | input | 1 | Upstream accepts the acknowledgment |
| uack_blk | output | BW | Acknowledged block |

## Verification
The assertions assume that the last-level cache raises `ugnt_valid` only while a forwarded request is waiting for its grant. They also assume that an upstream invalidation is never needed to release that grant. The bench keeps to both: it raises the grant pulse only after it has seen the forwarded request handshake, and it issues invalidations only while the slice is idle. Stray and repeated local acknowledgments are outside this contract. The bench still drives them on purpose, because the slice must ignore them.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FAN,
    ST_ACKUP,
    ST_UPREQ,
    ST_UPWAIT,
    ST_GRANT
  } fsm_e;

  typedef enum logic {
    ORG_UPSTREAM,
    ORG_LOCAL
  } origin_e;

endpackage

// File: rtl/cic_dir.sv
`timescale 1ns/1ps
module cic_dir #(
  parameter int N  = 16,
  parameter int NB = 8,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] rd_blk,
  output logic          rd_valid,
  output logic          rd_wperm,
  output logic [N-1:0]  rd_sharers,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_blk,
  input  logic          wr_valid,
  input  logic          wr_wperm,
  input  logic [N-1:0]  wr_sharers
);

  logic [NB-1:0] vld_q;
  logic [NB-1:0] wp_q;
  logic [N-1:0]  sh_q [NB];

  generate
    for (genvar g = 0; g < NB; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          wp_q[g]  <= 1'b0;
          sh_q[g]  <= '0;
        end else if (wr_en && (wr_blk == BW'(g))) begin
          vld_q[g] <= wr_valid;
          wp_q[g]  <= wr_wperm;
          sh_q[g]  <= wr_sharers;
        end
      end
    end
  endgenerate

  assign rd_valid   = vld_q[rd_blk];
  assign rd_wperm   = wp_q[rd_blk];
  assign rd_sharers = sh_q[rd_blk];

endmodule

// File: rtl/cic_ackctr.sv
`timescale 1ns/1ps
module cic_ackctr #(
  parameter int N = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_mask,
  input  logic [N-1:0] ack,
  output logic [N-1:0] fan_mask,
  output logic         fin
);

  function automatic logic [CW-1:0] count_ones(input logic [N-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < N; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  logic [N-1:0]  pend_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic [N-1:0]  hit;
  logic [CW-1:0] hit_n;

  assign hit   = ack & pend_q;
  assign hit_n = count_ones(hit);
  assign fin   = act_q && (hit_n == cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      cnt_q    <= '0;
      act_q    <= 1'b0;
      fan_mask <= '0;
    end else begin
      fan_mask <= load ? load_mask : '0;
      if (load) begin
        pend_q <= load_mask;
        cnt_q  <= count_ones(load_mask);
        act_q  <= |load_mask;
      end else if (act_q) begin
        pend_q <= pend_q & ~ack;
        cnt_q  <= cnt_q - hit_n;
        if (fin) act_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cic_combiner.sv
`timescale 1ns/1ps
module cic_combiner #(
  parameter int N  = 16,
  parameter int NB = 8,
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1,
  localparam int CIW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           creq_valid,
  output logic           creq_ready,
  input  logic [CIW-1:0] creq_core,
  input  logic [BW-1:0]  creq_blk,
  input  logic           creq_write,
  output logic           cgnt_valid,
  output logic [CIW-1:0] cgnt_core,
  output logic [BW-1:0]  cgnt_blk,
  output logic           cgnt_write,
  output logic [N-1:0]   linv_mask,
  output logic [BW-1:0]  linv_blk,
  input  logic [N-1:0]   lack,
  output logic           ureq_valid,
  input  logic           ureq_ready,
  output logic [BW-1:0]  ureq_blk,
  output logic           ureq_write,
  input  logic           ugnt_valid,
  input  logic           uinv_valid,
  output logic           uinv_ready,
  input  logic [BW-1:0]  uinv_blk,
  output logic           uack_valid,
  input  logic           uack_ready,
  output logic [BW-1:0]  uack_blk
);
  import cic_pkg::*;

  function automatic logic [N-1:0] core_bit(input logic [CIW-1:0] c);
    logic [N-1:0] r;
    r    = '0;
    r[c] = 1'b1;
    return r;
  endfunction

  fsm_e           st_q, st_d;
  origin_e        org_q, org_d;
  logic [BW-1:0]  blk_q, blk_d;
  logic [CIW-1:0] core_q, core_d;
  logic           wr_q, wr_d;

  logic [BW-1:0]  dir_rd_blk;
  logic           dir_valid, dir_wperm;
  logic [N-1:0]   dir_sharers;
  logic           dir_wr_en, dir_wr_valid, dir_wr_wperm;
  logic [N-1:0]   dir_wr_sharers;

  logic           ctr_load, ctr_fin;
  logic [N-1:0]   ctr_mask;

  logic [N-1:0]   req_bit;
  logic [N-1:0]   others;

  // events brought out for the checker
  logic           ev_inv_acc;
  logic           ev_req_acc;
  logic           ev_inv_empty;
  logic           ev_fan_up_done;

  assign uinv_ready = (st_q == ST_IDLE);
  assign creq_ready = (st_q == ST_IDLE) && !uinv_valid;
  assign ev_inv_acc = uinv_valid && uinv_ready;
  assign ev_req_acc = creq_valid && creq_ready;

  assign dir_rd_blk = (st_q != ST_IDLE) ? blk_q : (uinv_valid ? uinv_blk : creq_blk);
  assign req_bit    = core_bit((st_q == ST_IDLE) ? creq_core : core_q);
  assign others     = dir_sharers & ~req_bit;

  assign ev_inv_empty   = ev_inv_acc && (dir_sharers == '0);
  assign ev_fan_up_done = (st_q == ST_FAN) && ctr_fin && (org_q == ORG_UPSTREAM);

  cic_dir #(.N(N), .NB(NB)) dir_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_blk     (dir_rd_blk),
    .rd_valid   (dir_valid),
    .rd_wperm   (dir_wperm),
    .rd_sharers (dir_sharers),
    .wr_en      (dir_wr_en),
    .wr_blk     (blk_d),
    .wr_valid   (dir_wr_valid),
    .wr_wperm   (dir_wr_wperm),
    .wr_sharers (dir_wr_sharers)
  );

  cic_ackctr #(.N(N)) ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ctr_load),
    .load_mask (ctr_mask),
    .ack       (lack),
    .fan_mask  (linv_mask),
    .fin       (ctr_fin)
  );

  always_comb begin
    st_d           = st_q;
    org_d          = org_q;
    blk_d          = blk_q;
    core_d         = core_q;
    wr_d           = wr_q;
    ctr_load       = 1'b0;
    ctr_mask       = '0;
    dir_wr_en      = 1'b0;
    dir_wr_valid   = 1'b0;
    dir_wr_wperm   = 1'b0;
    dir_wr_sharers = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (ev_inv_acc) begin
          blk_d = uinv_blk;
          org_d = ORG_UPSTREAM;
          if (dir_sharers == '0) begin
            st_d = ST_ACKUP;
          end else begin
            ctr_load = 1'b1;
            ctr_mask = dir_sharers;
            st_d     = ST_FAN;
          end
        end else if (ev_req_acc) begin
          blk_d  = creq_blk;
          core_d = creq_core;
          wr_d   = creq_write;
          org_d  = ORG_LOCAL;
          if (!creq_write && dir_valid) begin
            dir_wr_en      = 1'b1;
            dir_wr_valid   = 1'b1;
            dir_wr_wperm   = dir_wperm;
            dir_wr_sharers = dir_sharers | req_bit;
            st_d           = ST_GRANT;
          end else if (creq_write && dir_valid && dir_wperm) begin
            if (others == '0) begin
              dir_wr_en      = 1'b1;
              dir_wr_valid   = 1'b1;
              dir_wr_wperm   = 1'b1;
              dir_wr_sharers = req_bit;
              st_d           = ST_GRANT;
            end else begin
              ctr_load = 1'b1;
              ctr_mask = others;
              st_d     = ST_FAN;
            end
          end else begin
            st_d = ST_UPREQ;
          end
        end
      end
      ST_FAN: begin
        if (ctr_fin) begin
          if (org_q == ORG_UPSTREAM) begin
            st_d = ST_ACKUP;
          end else begin
            dir_wr_en      = 1'b1;
            dir_wr_valid   = 1'b1;
            dir_wr_wperm   = 1'b1;
            dir_wr_sharers = req_bit;
            st_d           = ST_GRANT;
          end
        end
      end
      ST_ACKUP: begin
        if (uack_ready) begin
          dir_wr_en = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      ST_UPREQ: begin
        if (ureq_ready) st_d = ST_UPWAIT;
      end
      ST_UPWAIT: begin
        if (ugnt_valid) begin
          if (wr_q) begin
            if (others == '0) begin
              dir_wr_en      = 1'b1;
              dir_wr_valid   = 1'b1;
              dir_wr_wperm   = 1'b1;
              dir_wr_sharers = req_bit;
              st_d           = ST_GRANT;
            end else begin
              ctr_load = 1'b1;
              ctr_mask = others;
              st_d     = ST_FAN;
            end
          end else begin
            dir_wr_en      = 1'b1;
            dir_wr_valid   = 1'b1;
            dir_wr_wperm   = 1'b0;
            dir_wr_sharers = dir_sharers | req_bit;
            st_d           = ST_GRANT;
          end
        end
      end
      ST_GRANT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      org_q  <= ORG_UPSTREAM;
      blk_q  <= '0;
      core_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      org_q  <= org_d;
      blk_q  <= blk_d;
      core_q <= core_d;
      wr_q   <= wr_d;
    end
  end

  assign uack_valid = (st_q == ST_ACKUP);
  assign uack_blk   = blk_q;
  assign ureq_valid = (st_q == ST_UPREQ);
  assign ureq_blk   = blk_q;
  assign ureq_write = wr_q;
  assign cgnt_valid = (st_q == ST_GRANT);
  assign cgnt_core  = core_q;
  assign cgnt_blk   = blk_q;
  assign cgnt_write = wr_q;
  assign linv_blk   = blk_q;

endmodule

// File: rtl/cic_checker.sv
`timescale 1ns/1ps
module cic_checker #(
  parameter int N  = 16,
  parameter int NB = 8,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uinv_valid,
  input logic          uinv_ready,
  input logic          creq_ready,
  input logic          uack_valid,
  input logic          uack_ready,
  input logic [BW-1:0] uack_blk,
  input logic          ureq_valid,
  input logic          ureq_ready,
  input logic [BW-1:0] ureq_blk,
  input logic          ureq_write,
  input logic [N-1:0]  linv_mask,
  input logic          cgnt_valid,
  input logic          ev_inv_empty,
  input logic          ev_fan_up_done
);

  p_linv_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|linv_mask) |=> (linv_mask == '0));

  p_fan_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fan_up_done |=> uack_valid);

  p_single_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uack_valid && uack_ready) |=> !uack_valid);

  p_empty_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv_empty |=> (uack_valid && (linv_mask == '0)));

  p_grant_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cgnt_valid |=> !cgnt_valid);

  p_inv_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (uinv_valid && uinv_ready) |-> !creq_ready);

  p_fan_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|linv_mask) |-> (!uinv_ready && !creq_ready));

  p_fwd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ureq_valid |-> (!uinv_ready && !creq_ready));

  p_ack_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (uack_valid && !uack_ready) |=> (uack_valid && $stable(uack_blk)));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ureq_valid && !ureq_ready) |=> (ureq_valid && $stable(ureq_blk) && $stable(ureq_write)));

endmodule

bind cic_combiner cic_checker #(.N(N), .NB(NB)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .uinv_valid     (uinv_valid),
  .uinv_ready     (uinv_ready),
  .creq_ready     (creq_ready),
  .uack_valid     (uack_valid),
  .uack_ready     (uack_ready),
  .uack_blk       (uack_blk),
  .ureq_valid     (ureq_valid),
  .ureq_ready     (ureq_ready),
  .ureq_blk       (ureq_blk),
  .ureq_write     (ureq_write),
  .linv_mask      (linv_mask),
  .cgnt_valid     (cgnt_valid),
  .ev_inv_empty   (ev_inv_empty),
  .ev_fan_up_done (ev_fan_up_done)
);

// File: tb/cic_combiner_tb_top.sv
`timescale 1ns/1ps
module cic_combiner_tb_top;

  localparam int N  = 4;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       creq_valid = 1'b0;
  logic       creq_ready;
  logic [1:0] creq_core = '0;
  logic [1:0] creq_blk = '0;
  logic       creq_write = 1'b0;
  logic       cgnt_valid;
  logic [1:0] cgnt_core;
  logic [1:0] cgnt_blk;
  logic       cgnt_write;
  logic [3:0] linv_mask;
  logic [1:0] linv_blk;
  logic [3:0] lack = '0;
  logic       ureq_valid;
  logic       ureq_ready = 1'b1;
  logic [1:0] ureq_blk;
  logic       ureq_write;
  logic       ugnt_valid = 1'b0;
  logic       uinv_valid = 1'b0;
  logic       uinv_ready;
  logic [1:0] uinv_blk = '0;
  logic       uack_valid;
  logic       uack_ready = 1'b1;
  logic [1:0] uack_blk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic       m_v  [NB];
  logic       m_wp [NB];
  logic [3:0] m_sh [NB];

  always #5 clk = ~clk;

  cic_combiner #(.N(N), .NB(NB)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .creq_valid(creq_valid), .creq_ready(creq_ready), .creq_core(creq_core),
    .creq_blk(creq_blk), .creq_write(creq_write),
    .cgnt_valid(cgnt_valid), .cgnt_core(cgnt_core), .cgnt_blk(cgnt_blk),
    .cgnt_write(cgnt_write),
    .linv_mask(linv_mask), .linv_blk(linv_blk), .lack(lack),
    .ureq_valid(ureq_valid), .ureq_ready(ureq_ready), .ureq_blk(ureq_blk),
    .ureq_write(ureq_write), .ugnt_valid(ugnt_valid),
    .uinv_valid(uinv_valid), .uinv_ready(uinv_ready), .uinv_blk(uinv_blk),
    .uack_valid(uack_valid), .uack_ready(uack_ready), .uack_blk(uack_blk)
  );

  task automatic chk_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // read: hit when the model says valid (R8), else forwarded (R5)
  task automatic do_read(int c, int b);
    creq_valid = 1'b1; creq_core = 2'(c); creq_blk = 2'(b); creq_write = 1'b0;
    #1 chk_eq("R10", "creq_ready idle", int'(creq_ready), 1);
    tick();
    creq_valid = 1'b0;
    if (m_v[b]) begin
      chk_eq("R8", "read hit grant", int'(cgnt_valid), 1);
      chk_eq("R8", "grant core", int'(cgnt_core), c);
      chk_eq("R8", "no upstream on hit", int'(ureq_valid), 0);
      tick();
    end else begin
      chk_eq("R5", "read miss forwarded", int'(ureq_valid), 1);
      chk_eq("R5", "forward is read", int'(ureq_write), 0);
      chk_eq("R5", "forward blk", int'(ureq_blk), b);
      tick();
      chk_eq("R6", "no grant before upstream", int'(cgnt_valid), 0);
      ugnt_valid = 1'b1;
      tick();
      ugnt_valid = 1'b0;
      chk_eq("R8", "read grant after upstream", int'(cgnt_valid), 1);
      tick();
      m_v[b]  = 1'b1;
      m_wp[b] = 1'b0;
    end
    m_sh[b] = m_sh[b] | 4'(1 << c);
  endtask

  task automatic do_write(int c, int b);
    logic [3:0] oth;
    bit up;
    string rq;
    int left;
    oth  = m_sh[b] & ~4'(1 << c);
    up   = !(m_v[b] && m_wp[b]);
    rq   = up ? "R7" : "R9";
    creq_valid = 1'b1; creq_core = 2'(c); creq_blk = 2'(b); creq_write = 1'b1;
    #1 chk_eq("R10", "creq_ready idle", int'(creq_ready), 1);
    tick();
    creq_valid = 1'b0;
    if (up) begin
      chk_eq("R6", "write forwarded", int'(ureq_valid), 1);
      chk_eq("R6", "forward is write", int'(ureq_write), 1);
      chk_eq("R6", "forward blk", int'(ureq_blk), b);
      tick();
      chk_eq("R6", "no grant before upstream", int'(cgnt_valid), 0);
      ugnt_valid = 1'b1;
      tick();
      ugnt_valid = 1'b0;
    end
    if (oth != 4'd0) begin
      chk_eq(rq, "local inval of other sharers", int'(linv_mask), int'(oth));
      chk_eq(rq, "no grant during fan-out", int'(cgnt_valid), 0);
      left = $countones(oth);
      for (int i = 0; i < N; i++) begin
        if (oth[i]) begin
          lack = 4'(1 << i);
          tick();
          lack = '0;
          left--;
          if (left > 0) chk_eq(rq, "grant waits for acks", int'(cgnt_valid), 0);
        end
      end
    end
    chk_eq(rq, "write grant", int'(cgnt_valid), 1);
    chk_eq(rq, "write grant type", int'(cgnt_write), 1);
    chk_eq(rq, "write grant core", int'(cgnt_core), c);
    tick();
    m_v[b]  = 1'b1;
    m_wp[b] = 1'b1;
    m_sh[b] = 4'(1 << c);
  endtask

  task automatic do_inv(int b, bit stray);
    logic [3:0] exp;
    int left;
    bit dup_done;
    exp = m_sh[b];
    dup_done = 1'b0;
    uinv_valid = 1'b1; uinv_blk = 2'(b);
    #1 chk_eq("R10", "uinv_ready idle", int'(uinv_ready), 1);
    tick();
    uinv_valid = 1'b0;
    chk_eq("R1", "fan-out mask", int'(linv_mask), int'(exp));
    if (exp == 4'd0) begin
      chk_eq("R3", "empty vector ack next cycle", int'(uack_valid), 1);
      chk_eq("R3", "ack blk", int'(uack_blk), b);
      tick();
      chk_eq("R2", "single ack", int'(uack_valid), 0);
    end else begin
      chk_eq("R2", "no early ack", int'(uack_valid), 0);
      if (stray && (~exp != 4'd0)) begin
        lack = ~exp;
        tick();
        lack = '0;
        chk_eq("R4", "stray ack ignored", int'(uack_valid), 0);
        chk_eq("R1", "fan-out one cycle", int'(linv_mask), 0);
      end
      left = $countones(exp);
      for (int i = 0; i < N; i++) begin
        if (exp[i]) begin
          lack = 4'(1 << i);
          tick();
          lack = '0;
          left--;
          if (left > 0) begin
            chk_eq("R4", "ack waits for all sharers", int'(uack_valid), 0);
            if (stray && !dup_done) begin
              dup_done = 1'b1;
              lack = 4'(1 << i);
              tick();
              lack = '0;
              chk_eq("R4", "repeated ack ignored", int'(uack_valid), 0);
            end
          end
        end
      end
      chk_eq("R2", "combined ack", int'(uack_valid), 1);
      chk_eq("R2", "combined ack blk", int'(uack_blk), b);
      tick();
      chk_eq("R2", "single ack", int'(uack_valid), 0);
    end
    m_v[b]  = 1'b0;
    m_wp[b] = 1'b0;
    m_sh[b] = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_v[b] = 1'b0; m_wp[b] = 1'b0; m_sh[b] = '0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    // R11 reset state
    chk_eq("R11", "uinv_ready", int'(uinv_ready), 1);
    chk_eq("R11", "creq_ready", int'(creq_ready), 1);
    chk_eq("R11", "uack_valid", int'(uack_valid), 0);
    chk_eq("R11", "ureq_valid", int'(ureq_valid), 0);
    chk_eq("R11", "cgnt_valid", int'(cgnt_valid), 0);
    chk_eq("R11", "linv_mask", int'(linv_mask), 0);
    for (int b = 0; b < NB; b++) do_inv(b, 1'b0);   // R11: all empty

    // sweep every sharer set through invalidation
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < N; c++) if (s[c]) do_read(c, s % NB);
      do_inv(s % NB, 1'b1);
    end

    // write paths over every sharer set and writer
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < N; w++) begin
        int b;
        b = (s + w) % NB;
        for (int c = 0; c < N; c++) if (s[c]) do_read(c, b);
        do_write(w, b);
        do_write((w + 1) % N, b);
        do_write((w + 1) % N, b);
        do_inv(b, 1'b0);
      end
    end

    // R10 priority, R12 holding under back-pressure
    creq_valid = 1'b1; creq_core = 2'd1; creq_blk = 2'd0; creq_write = 1'b0;
    uinv_valid = 1'b1; uinv_blk = 2'd0;
    #1 chk_eq("R10", "core held when inval valid", int'(creq_ready), 0);
    uack_ready = 1'b0;
    tick();
    uinv_valid = 1'b0;
    chk_eq("R3", "empty ack", int'(uack_valid), 1);
    chk_eq("R10", "busy blocks core", int'(creq_ready), 0);
    tick();
    chk_eq("R12", "ack held", int'(uack_valid), 1);
    chk_eq("R12", "ack blk held", int'(uack_blk), 0);
    tick();
    chk_eq("R12", "ack still held", int'(uack_valid), 1);
    uack_ready = 1'b1;
    tick();
    chk_eq("R2", "ack dropped", int'(uack_valid), 0);
    ureq_ready = 1'b0;
    #1 chk_eq("R10", "core accepted when idle", int'(creq_ready), 1);
    tick();
    creq_valid = 1'b0;
    chk_eq("R5", "read forwarded", int'(ureq_valid), 1);
    tick();
    chk_eq("R12", "request held", int'(ureq_valid), 1);
    chk_eq("R12", "request type held", int'(ureq_write), 0);
    ureq_ready = 1'b1;
    tick();
    chk_eq("R12", "request dropped", int'(ureq_valid), 0);
    ugnt_valid = 1'b1;
    tick();
    ugnt_valid = 1'b0;
    chk_eq("R8", "grant after upstream", int'(cgnt_valid), 1);
    tick();
    m_v[0] = 1'b1; m_wp[0] = 1'b0; m_sh[0] = 4'b0010;
    do_inv(0, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule